// File: doc/BRIEF.md
# Nonvolatile Wiper Setting Sequencer

This block holds the 6-bit setting of a 64-step digital potentiometer wiper and keeps a nonvolatile copy of that setting. It takes single-cycle command strobes from a serial front end that has already decoded them. The commands write the wiper, read back either the wiper or the saved copy, save the wiper into the nonvolatile cell, reload the wiper from the cell, and set or clear a software write-protect flag. The bus protocol, the address decoding and the resistor ladder sit outside this block.

After power-on reset the wiper is held at mid-range for a timed reload, and then the saved code is applied. Saving takes much longer than reloading, and `busy` stays high for the whole of either operation. A saving lockout window starts at reset release, and software write protect also blocks saving. The nonvolatile cell is modelled as a register that reset does not clear. All durations are parameters counted in clock cycles.

Top module: `wiper_nv_seq`

## Requirements
- R1: While `rst_n` is low the wiper holds the mid-range code (bit W-1 set, all other bits clear, 0x20 for W=6), `busy` is high, and `wp_on`, `cmd_err` and `rd_valid` are low.
- R2: After reset release `busy` stays high for exactly RESTORE_CYC cycles. The wiper then takes the code held in the nonvolatile cell.
- R3: A lone write strobe while idle sets the wiper to `wr_code` at the next clock edge. The nonvolatile cell is left unchanged.
- R4: A lone read strobe while idle gives `rd_valid` high for one cycle after the next edge. `rd_code` then holds the wiper when `rd_src` is 0 and the nonvolatile cell when `rd_src` is 1.
- R5: An accepted save keeps `busy` high for exactly STORE_CYC cycles. When it ends, the nonvolatile cell holds the wiper value from the cycle of the command.
- R6: A save strobe that arrives less than LOCK_CYC cycles after reset release is rejected. `cmd_err` pulses, `busy` stays low and the cell is unchanged.
- R7: While `wp_on` is set, a save strobe is ignored and flagged on `cmd_err`, and the cell is unchanged. Clearing protection allows saving again. Reset clears `wp_on`.
- R8: A reload strobe while idle keeps `busy` high for exactly RESTORE_CYC cycles. The wiper then equals the cell content.
- R9: Any strobe that arrives while `busy` is high has no effect, and `cmd_err` is high for one cycle afterwards.
- R10: More than one strobe in the same cycle is rejected as a whole, with a one-cycle `cmd_err` and no change to the wiper or the flag.
- R11: The cell content survives reset, so the next power-on reload applies the last saved code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| do_write | input | 1 | Strobe: load the wiper from `wr_code` |
| do_read | input | 1 | Strobe: read back the source chosen by `rd_src` |
| do_save | input | 1 | Strobe: copy the wiper into the nonvolatile cell |
| do_reload | input | 1 | Strobe: load the wiper from the nonvolatile cell |
| do_prot_on | input | 1 | Strobe: set software write protect |
| do_prot_off | input | 1 | Strobe: clear software write protect |
| wr_code | input | W | Code to write into the wiper |
| rd_src | input | 1 | Read source: 0 selects the wiper, 1 selects the cell |
| wiper | output | W | Current wiper code |
| rd_code | output | W | Read-back data |
| rd_valid | output | 1 | One-cycle pulse that marks `rd_code` as valid |
| busy | output | 1 | A save or reload is in progress |
| wp_on | output | 1 | Software write protect is active |
| cmd_err | output | 1 | One-cycle pulse for a rejected or ignored strobe |

## Verification
The hardest case to reach is a save strobe that falls inside the lockout window after reset. The power-on reload has to finish first, so that the strobe is not rejected for being busy, and the lockout must still be running. The bench sets the lockout longer than the reload, waits for `busy` to drop, and then issues the save at once. Strobes that collide with a running save are placed a fixed number of cycles after the save is issued, which puts them well inside the busy period.

// File: rtl/wiper_nv_pkg.sv
// Shared definitions for the wiper sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package wiper_nv_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_RELOAD = 2'd1,
        SEQ_SAVE   = 2'd2
    } seq_state_e;

    // Number of command strobes the sequencer decodes.
    localparam int NUM_STROBES = 6;
endpackage

// File: rtl/wnv_timer.sv
// Countdown timer for save and reload durations.
// When load is high the count takes load_val. Otherwise it falls by one
// each cycle until it reaches zero. done is high while the count is zero.
// Assumes: load_val fits in CW bits; RST_VAL is the count held during reset.
module wnv_timer #(
    parameter int CW      = 8,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    // Load, count down, or hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CW'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // Once expired, the timer stays expired until it is reloaded.
    AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done); // R5
endmodule

// File: rtl/wnv_lockout.sv
// Save lockout window after power-on.
// The counter starts at LOCK_CYC in reset and falls to zero. locked is high
// while the counter is not zero.
// Assumes: LOCK_CYC >= 1.
module wnv_lockout #(
    parameter int LOCK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic locked
);
    localparam int LW = $clog2(LOCK_CYC + 1);

    logic [LW-1:0] win_q;

    // Count the window down once from reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= LW'(LOCK_CYC);
        else if (win_q != '0)
            win_q <= win_q - 1'b1;
    end

    assign locked = (win_q != '0);

    // Once the window has closed it stays closed until the next reset.
    AST_LOCK_NEVER_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> !locked); // R6
endmodule

// File: rtl/wnv_cell.sv
// Model of the nonvolatile cell that holds the saved wiper code.
// The register has no reset and starts from INIT_CODE, so its content
// survives the block reset in the same way as a real nonvolatile store.
// Assumes: wr_en is a single-cycle pulse at the end of a save.
module wnv_cell #(
    parameter int W         = 6,
    parameter int INIT_CODE = 0
) (
    input  logic         clk,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data
);
    logic [W-1:0] mem_q = W'(INIT_CODE);

    // Commit a new code at the end of a save.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q <= wr_data;
    end

    assign rd_data = mem_q;
endmodule

// File: rtl/wiper_nv_seq.sv
// Wiper register with a nonvolatile copy: sequencer top level.
// Decodes one-hot command strobes, runs the power-on midscale reload,
// timed saves and reloads, the save lockout after power-on, and the
// software write protect.
// Assumes: strobes are single-cycle, synchronous to clk and already
// decoded from the serial bus; durations are given in clock cycles.
module wiper_nv_seq
    import wiper_nv_pkg::*;
#(
    parameter int W           = 6,
    parameter int RESTORE_CYC = 15000,
    parameter int STORE_CYC   = 1300000,
    parameter int LOCK_CYC    = 27000,
    parameter int NV_INIT     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         do_write,
    input  logic         do_read,
    input  logic         do_save,
    input  logic         do_reload,
    input  logic         do_prot_on,
    input  logic         do_prot_off,
    input  logic [W-1:0] wr_code,
    input  logic         rd_src,
    output logic [W-1:0] wiper,
    output logic [W-1:0] rd_code,
    output logic         rd_valid,
    output logic         busy,
    output logic         wp_on,
    output logic         cmd_err
);
    localparam int MAXT = (STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [W-1:0] MIDSCALE = W'(1) << (W - 1);

    seq_state_e   state_q;
    logic [W-1:0] wiper_q, stage_q, nv_code, rd_code_q;
    logic         wp_q, err_q, rdv_q;
    logic         tmr_done, tmr_load, locked, cell_we;
    logic [CW-1:0] tmr_val;
    logic [NUM_STROBES-1:0] strobes;
    logic         any_cmd, multi_cmd, accept;
    logic         acc_write, acc_read, acc_save, acc_reload, acc_pon, acc_poff;
    logic         save_ok, save_bad, err_d;

    assign strobes   = {do_write, do_read, do_save, do_reload, do_prot_on, do_prot_off};
    assign any_cmd   = (strobes != '0);
    assign multi_cmd = !$onehot0(strobes);
    assign busy      = (state_q != SEQ_IDLE);
    assign accept    = any_cmd && !multi_cmd && !busy;

    assign acc_write  = accept && do_write;
    assign acc_read   = accept && do_read;
    assign acc_save   = accept && do_save;
    assign acc_reload = accept && do_reload;
    assign acc_pon    = accept && do_prot_on;
    assign acc_poff   = accept && do_prot_off;

    assign save_ok  = acc_save && !wp_q && !locked;
    assign save_bad = acc_save && !save_ok;
    assign err_d    = (any_cmd && (busy || multi_cmd)) || save_bad;

    assign tmr_load = acc_reload || save_ok;
    assign tmr_val  = acc_reload ? CW'(RESTORE_CYC - 1) : CW'(STORE_CYC - 1);
    assign cell_we  = (state_q == SEQ_SAVE) && tmr_done;

    wnv_timer #(.CW(CW), .RST_VAL(RESTORE_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    wnv_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .locked (locked)
    );

    wnv_cell #(.W(W), .INIT_CODE(NV_INIT)) u_cell (
        .clk     (clk),
        .wr_en   (cell_we),
        .wr_data (stage_q),
        .rd_data (nv_code)
    );

    // Sequencer state: power-on reload, then idle, save or reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_RELOAD;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (acc_reload)   state_q <= SEQ_RELOAD;
                    else if (save_ok) state_q <= SEQ_SAVE;
                end
                SEQ_RELOAD: if (tmr_done) state_q <= SEQ_IDLE;
                SEQ_SAVE:   if (tmr_done) state_q <= SEQ_IDLE;
                default:    state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Wiper register: midscale in reset, direct writes, reload completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wiper_q <= MIDSCALE;
        else if (acc_write)
            wiper_q <= wr_code;
        else if (state_q == SEQ_RELOAD && tmr_done)
            wiper_q <= nv_code;
    end

    // Capture the code to be saved when the save is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (save_ok)
            stage_q <= wiper_q;
    end

    // Volatile software write-protect flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wp_q <= 1'b0;
        else if (acc_pon)
            wp_q <= 1'b1;
        else if (acc_poff)
            wp_q <= 1'b0;
    end

    // Read-back data and the one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_code_q <= '0;
            rdv_q     <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            rdv_q <= acc_read;
            err_q <= err_d;
            if (acc_read)
                rd_code_q <= rd_src ? nv_code : wiper_q;
        end
    end

    assign wiper    = wiper_q;
    assign rd_code  = rd_code_q;
    assign rd_valid = rdv_q;
    assign wp_on    = wp_q;
    assign cmd_err  = err_q;

    AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && any_cmd) |=> cmd_err); // R9

    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && do_write && state_q == SEQ_SAVE) |=> $stable(wiper)); // R9

    AST_PROTECT_BLOCKS_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_q && do_save && !busy) |=> (state_q == SEQ_IDLE && cmd_err)); // R7

    AST_LOCKED_BLOCKS_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && do_save && !busy) |=> (state_q != SEQ_SAVE)); // R6

    AST_CELL_ONLY_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(nv_code) |-> $past(state_q == SEQ_SAVE)); // R5

    AST_MULTI_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_cmd && !busy) |=> (cmd_err && !rd_valid)); // R10

    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (do_read && !multi_cmd && !busy) |=> rd_valid); // R4
endmodule

// File: tb/wiper_nv_seq_test.sv
module wiper_nv_seq_test;
    localparam int W    = 6;
    localparam int T_RS = 12;
    localparam int T_ST = 40;
    localparam int T_LK = 30;
    localparam int INIT = 42;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic do_write = 0, do_read = 0, do_save = 0, do_reload = 0;
    logic do_prot_on = 0, do_prot_off = 0, rd_src = 0;
    logic [W-1:0] wr_code = '0;
    logic [W-1:0] wiper, rd_code;
    logic rd_valid, busy, wp_on, cmd_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wiper_nv_seq #(.W(W), .RESTORE_CYC(T_RS), .STORE_CYC(T_ST),
                   .LOCK_CYC(T_LK), .NV_INIT(INIT)) uut (
        .clk(clk), .rst_n(rst_n), .do_write(do_write), .do_read(do_read),
        .do_save(do_save), .do_reload(do_reload), .do_prot_on(do_prot_on),
        .do_prot_off(do_prot_off), .wr_code(wr_code), .rd_src(rd_src),
        .wiper(wiper), .rd_code(rd_code), .rd_valid(rd_valid), .busy(busy),
        .wp_on(wp_on), .cmd_err(cmd_err)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_strobes();
        do_write = 0; do_read = 0; do_save = 0; do_reload = 0;
        do_prot_on = 0; do_prot_off = 0;
    endtask

    // Drive one set of strobes for one cycle; outputs are sampled after the edge.
    task automatic pulse(input logic w, input logic r, input logic s,
                         input logic l, input logic pon, input logic poff);
        do_write = w; do_read = r; do_save = s; do_reload = l;
        do_prot_on = pon; do_prot_off = poff;
        tick();
        clear_strobes();
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 10000) begin
            n++;
            tick();
        end
    endtask

    task automatic read_cell(output int v);
        rd_src = 1;
        pulse(0, 1, 0, 0, 0, 0);
        v = rd_code;
    endtask

    task automatic do_reset();
        rst_n = 0;
        tick(); tick(); tick();
        rst_n = 1;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int n, v;
        @(negedge clk);
        do_reset();
        // R1: reset holds midscale and busy with the flags clear.
        rst_n = 0;
        tick();
        check(wiper == 6'h20, "R1 midscale", wiper, 32);
        check(busy == 1'b1, "R1 busy", busy, 1);
        check(wp_on == 0 && cmd_err == 0 && rd_valid == 0, "R1 flags", wp_on, 0);
        rst_n = 1;
        // R2: power-on reload length and result.
        busy_len(n);
        check(n == T_RS, "R2 reload cycles", n, T_RS);
        check(wiper == INIT, "R2 reload code", wiper, INIT);
        // R6: a save right after the reload still falls inside the lockout.
        pulse(0, 0, 1, 0, 0, 0);
        check(cmd_err == 1, "R6 err", cmd_err, 1);
        check(busy == 0, "R6 no busy", busy, 0);
        read_cell(v);
        check(v == INIT, "R6 cell kept", v, INIT);
        // R3/R4: sweep every wiper code.
        for (int c = 0; c < 64; c++) begin
            wr_code = W'(c);
            pulse(1, 0, 0, 0, 0, 0);
            check(wiper == c, "R3 write", wiper, c);
            rd_src = 0;
            pulse(0, 1, 0, 0, 0, 0);
            check(rd_valid == 1 && rd_code == c, "R4 read wiper", rd_code, c);
            tick();
            check(rd_valid == 0, "R4 pulse width", rd_valid, 0);
            read_cell(v);
            check(v == INIT, "R3 cell unchanged", v, INIT);
        end
        // Wait until the lockout window has surely closed.
        for (int i = 0; i < T_LK; i++) tick();
        // R5/R8: save then reload for a spread of codes.
        for (int c = 3; c < 64; c += 9) begin
            wr_code = W'(c);
            pulse(1, 0, 0, 0, 0, 0);
            pulse(0, 0, 1, 0, 0, 0);
            busy_len(n);
            check(n == T_ST, "R5 save cycles", n, T_ST);
            read_cell(v);
            check(v == c, "R5 cell code", v, c);
            wr_code = W'(63 - c);
            pulse(1, 0, 0, 0, 0, 0);
            pulse(0, 0, 0, 1, 0, 0);
            busy_len(n);
            check(n == T_RS, "R8 reload cycles", n, T_RS);
            check(wiper == c, "R8 reload code", wiper, c);
        end
        // R9: strobes during a save are rejected.
        wr_code = 6'h07;
        pulse(1, 0, 0, 0, 0, 0);
        pulse(0, 0, 1, 0, 0, 0);
        tick(); tick();
        wr_code = 6'h3F;
        pulse(1, 0, 0, 0, 0, 0);
        check(cmd_err == 1, "R9 err on write", cmd_err, 1);
        check(wiper == 6'h07, "R9 wiper kept", wiper, 7);
        tick();
        check(cmd_err == 0, "R9 err one cycle", cmd_err, 0);
        pulse(0, 0, 0, 0, 1, 0);
        check(wp_on == 0, "R9 protect ignored", wp_on, 0);
        busy_len(n);
        read_cell(v);
        check(v == 7, "R5 save under traffic", v, 7);
        // R7: write protect blocks saving.
        pulse(0, 0, 0, 0, 1, 0);
        check(wp_on == 1, "R7 protect set", wp_on, 1);
        wr_code = 6'h22;
        pulse(1, 0, 0, 0, 0, 0);
        pulse(0, 0, 1, 0, 0, 0);
        check(cmd_err == 1 && busy == 0, "R7 save ignored", busy, 0);
        read_cell(v);
        check(v == 7, "R7 cell kept", v, 7);
        pulse(0, 0, 0, 0, 0, 1);
        check(wp_on == 0, "R7 protect clear", wp_on, 0);
        pulse(0, 0, 1, 0, 0, 0);
        busy_len(n);
        read_cell(v);
        check(v == 6'h22, "R7 save after clear", v, 34);
        // R10: two strobes together are rejected.
        wr_code = 6'h01;
        pulse(1, 1, 0, 0, 0, 0);
        check(cmd_err == 1 && rd_valid == 0, "R10 err", cmd_err, 1);
        check(wiper == 6'h22, "R10 wiper kept", wiper, 34);
        pulse(0, 0, 0, 0, 1, 1);
        check(wp_on == 0, "R10 flag kept", wp_on, 0);
        // R7/R11: reset clears protect and keeps the cell.
        pulse(0, 0, 0, 0, 1, 0);
        do_reset();
        check(wp_on == 0, "R7 protect reset", wp_on, 0);
        busy_len(n);
        check(wiper == 6'h22, "R11 cell survives reset", wiper, 34);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule